// File: doc/BRIEF.md
# DMA-Fed Cipher Block Input Loader

This block gathers 32-bit words from a DMA engine and assembles them into one 128-bit input block for a block-cipher core. A pulse on `phase_start` opens an input phase. While that phase is open and `dma_in_en` is set, the block raises `dma_req` once for each word it still lacks. The DMA engine answers each request with a single-beat write to one fixed data port, signalled by `dma_ack` together with `dma_wdata`.

Words are packed into the block from the most significant word down. They are stored exactly as they arrive. After the fourth accepted word, the block raises `blk_valid` and holds it, with the data unchanged, until the core answers with `blk_ready`. The block then stays idle until the next phase pulse. Messages are handled as a whole number of 128-bit blocks, one block per input phase.

Top module: `dma_block_loader`

## Requirements
- R1: A synchronous active-high `rst` clears the pending request, the word count and `blk_valid`. The cycle after reset, `dma_req` and `blk_valid` are 0, and a new phase starts from the first word.
- R2: When `dma_in_en` is 0 at a clock edge, `dma_req` is 0 after that edge.
- R3: Within an open input phase that still needs words, `dma_req` after each edge equals `dma_in_en` at that edge. The only exception is an edge at which a beat was accepted. The phase opens at the edge where `phase_start` is 1 while the block is idle.
- R4: A beat is accepted at an edge where `dma_req` and `dma_ack` are both 1. After that edge `dma_req` is 0 for at least one cycle.
- R5: Exactly four accepted beats complete a block. `blk_valid` rises right after the edge that accepts the fourth beat.
- R6: The first accepted word lands in `blk_data[127:96]`, the second in `[95:64]`, the third in `[63:32]` and the fourth in `[31:0]`.
- R7: Each word is stored bit for bit as presented on `dma_wdata`, with no byte or bit reordering.
- R8: While `blk_valid` is 1 and `blk_ready` is 0, `blk_valid` stays 1, `blk_data` stays stable and `dma_req` stays 0. An edge with `blk_ready` at 1 clears `blk_valid`. No request follows until the next `phase_start`.
- R9: Clearing `dma_in_en` in the middle of a block keeps the count of words already received. Setting it again resumes at the next missing word position.
- R10: A `phase_start` pulse while a phase is filling or a block is waiting has no effect.
- R11: A `dma_ack` while `dma_req` is 0 accepts no word and does not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_in_en | input | 1 | Enables DMA requests on the input side |
| phase_start | input | 1 | One-cycle pulse that opens an input phase |
| dma_req | output | 1 | Request for one more word (registered) |
| dma_ack | input | 1 | DMA single-beat write strobe |
| dma_wdata | input | 32 | Word written by the DMA engine |
| blk_valid | output | 1 | Assembled block is available |
| blk_ready | input | 1 | Core accepts the block |
| blk_data | output | 128 | Assembled block, first word in the top bits |

## Verification
The assertions assume a DMA engine that never presents `dma_ack` without a prior request, or that treats such a strobe as harmless. They also assume `phase_start` is a pulse, not a level. The stimulus drives `dma_ack` only in cycles where it has sampled `dma_req` high, with two deliberate exceptions. One is stray acknowledges sent while no request is pending. The other is acknowledges sent while the enable is low, used to probe the ignore paths. Phase pulses are also sent while a block is still filling or waiting, to exercise the ignore path. The enable is toggled at arbitrary cycles, including right after an accepted beat.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_FILL = 2'd1,
    LD_HOLD = 2'd2
  } ld_state_t;
endpackage

// File: rtl/dbl_ctrl.sv
module dbl_ctrl
  import dbl_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_in_en,
  input  logic             phase_start,
  input  logic             dma_ack,
  input  logic             blk_ready,
  output logic             dma_req,
  output logic             blk_valid,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  ld_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             req_q;

  assign wr_en     = req_q && dma_ack;
  assign wr_idx    = cnt;
  assign dma_req   = req_q;
  assign blk_valid = (state == LD_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LD_IDLE;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      unique case (state)
        LD_IDLE: begin
          req_q <= 1'b0;
          if (phase_start) begin
            state <= LD_FILL;
            cnt   <= '0;
            req_q <= dma_in_en;
          end
        end
        LD_FILL: begin
          if (wr_en) begin
            cnt   <= cnt + CNT_W'(1);
            req_q <= 1'b0;
            if (cnt == LAST) state <= LD_HOLD;
          end else begin
            req_q <= dma_in_en;
          end
        end
        LD_HOLD: begin
          req_q <= 1'b0;
          if (blk_ready) begin
            state <= LD_IDLE;
            cnt   <= '0;
          end
        end
        default: begin
          state <= LD_IDLE;
          req_q <= 1'b0;
        end
      endcase
    end
  end

  // R2
  req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(dma_in_en));
  // R4
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_ack) |=> !dma_req);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WORDS));
  // R8
  no_req_while_valid_chk: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> !dma_req);
  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready) |=> blk_valid);
  // R11
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!dma_req && state == LD_FILL) |=> $stable(cnt));
endmodule

// File: rtl/dbl_packer.sv
module dbl_packer #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(WORDS + 1),
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BLK_W-1:0]  blk_data
);
  for (genvar i = 0; i < WORDS; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE = IDX_W'(i);
    localparam int HI = WORD_W * (WORDS - i) - 1;
    logic [WORD_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == LANE) lane_q <= wr_data;
    end

    assign blk_data[HI -: WORD_W] = lane_q;
  end
endmodule

// File: rtl/dma_block_loader.sv
module dma_block_loader #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_in_en,
  input  logic              phase_start,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [WORD_W-1:0] dma_wdata,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [BLK_W-1:0]  blk_data
);
  localparam int CNT_W = $clog2(WORDS + 1);

  logic             wr_en;
  logic [CNT_W-1:0] wr_idx;

  dbl_ctrl #(.WORDS(WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .dma_in_en   (dma_in_en),
    .phase_start (phase_start),
    .dma_ack     (dma_ack),
    .blk_ready   (blk_ready),
    .dma_req     (dma_req),
    .blk_valid   (blk_valid),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx)
  );

  dbl_packer #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(CNT_W), .BLK_W(BLK_W)) u_pack (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (dma_wdata),
    .blk_data (blk_data)
  );

  // R8
  data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready) |=> $stable(blk_data));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!dma_req && !blk_valid));
endmodule

// File: tb/dma_block_loader_bench.sv
module dma_block_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst, dma_in_en, phase_start, dma_ack, blk_ready;
  logic [31:0]  dma_wdata;
  logic         dma_req, blk_valid;
  logic [127:0] blk_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference
  bit          m_req, m_valid, m_open;
  logic [127:0] m_data;
  logic [31:0] m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_block_loader u_dma_block_loader (
    .clk(clk), .rst(rst), .dma_in_en(dma_in_en), .phase_start(phase_start),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(string r, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic step();
    bit acc;
    @(posedge clk);
    acc = m_req && dma_ack;
    if (rst) begin
      m_req = 0; m_valid = 0; m_open = 0; m_q.delete();
    end else if (m_valid) begin
      if (blk_ready) m_valid = 0;
    end else if (m_open) begin
      if (acc) begin
        m_q.push_back(dma_wdata);
        m_req = 0;
        if (m_q.size() == 4) begin
          m_valid = 1; m_open = 0;
          for (int i = 0; i < 4; i++) m_data[127-32*i -: 32] = m_q[i];
        end
      end else m_req = dma_in_en;
    end else if (phase_start) begin
      m_open = 1; m_q.delete(); m_req = dma_in_en;
    end
    #1;
    cycles++;
    check(tag, "dma_req", {127'd0, dma_req}, {127'd0, m_req});
    check(tag, "blk_valid", {127'd0, blk_valid}, {127'd0, m_valid});
    if (m_valid) check(tag, "blk_data", blk_data, m_data);
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  endtask

  task automatic idle_inputs();
    phase_start = 0; dma_ack = 0; blk_ready = 0; dma_wdata = '0;
  endtask

  task automatic pulse_phase();
    phase_start = 1; step(); phase_start = 0;
  endtask

  // wait for a request, then acknowledge it after 'lag' extra cycles
  task automatic give_word(logic [31:0] w, int lag);
    while (!dma_req) step();
    for (int k = 0; k < lag; k++) step();
    dma_ack = 1; dma_wdata = w; step();
    dma_ack = 0; dma_wdata = '0;
  endtask

  task automatic take_block();
    blk_ready = 1; step(); blk_ready = 0;
  endtask

  initial begin
    rst = 1; dma_in_en = 0; idle_inputs();
    // R1: reset state
    tag = "R1";
    step(); step();
    rst = 0;
    step();
    check("R1", "req after reset", {127'd0, dma_req}, 128'd0);
    check("R1", "valid after reset", {127'd0, blk_valid}, 128'd0);

    // enabled but no phase: nothing requested
    tag = "R3"; dma_in_en = 1;
    for (int k = 0; k < 3; k++) step();
    check("R3", "no req before phase", {127'd0, dma_req}, 128'd0);

    // R3 R4 R5 R6: back-to-back words
    pulse_phase();
    check("R3", "req after phase", {127'd0, dma_req}, 128'd1);
    tag = "R6";
    give_word(32'h0123_4567, 0);
    check("R4", "req low after beat", {127'd0, dma_req}, 128'd0);
    give_word(32'h89AB_CDEF, 0);
    give_word(32'hDEAD_BEEF, 0);
    give_word(32'hCAFE_F00D, 0);
    check("R5", "valid after fourth", {127'd0, blk_valid}, 128'd1);
    check("R6", "word order", blk_data, 128'h0123_4567_89AB_CDEF_DEAD_BEEF_CAFE_F00D);

    // R8 R10 R11: hold, stray phase and ack ignored
    tag = "R8";
    for (int k = 0; k < 4; k++) step();
    tag = "R10"; pulse_phase();
    tag = "R11"; dma_ack = 1; dma_wdata = 32'hFFFF_FFFF; step(); dma_ack = 0;
    check("R8", "data held", blk_data, 128'h0123_4567_89AB_CDEF_DEAD_BEEF_CAFE_F00D);
    tag = "R8"; take_block();
    for (int k = 0; k < 3; k++) step();
    check("R8", "no req after accept", {127'd0, dma_req}, 128'd0);

    // R2 R9: enable low at phase start, toggled mid-block
    tag = "R2"; dma_in_en = 0;
    pulse_phase();
    for (int k = 0; k < 3; k++) step();
    check("R2", "no req while disabled", {127'd0, dma_req}, 128'd0);
    dma_in_en = 1; tag = "R9";
    give_word(32'h8000_0001, 1);
    give_word(32'h0000_00FF, 0);
    dma_in_en = 0;
    tag = "R11"; dma_ack = 1; dma_wdata = 32'h5555_5555;
    for (int k = 0; k < 4; k++) step();
    dma_ack = 0;
    tag = "R10"; pulse_phase();
    dma_in_en = 1; tag = "R9";
    give_word(32'h1234_00AA, 3);
    give_word(32'hF0F0_0F0F, 2);
    check("R7", "no swap", blk_data, 128'h8000_0001_0000_00FF_1234_00AA_F0F0_0F0F);
    check("R9", "resume count", {127'd0, blk_valid}, 128'd1);
    take_block();

    // R1: reset mid-block, then a fresh full block
    tag = "R1";
    pulse_phase();
    give_word(32'h1111_1111, 0);
    give_word(32'h2222_2222, 0);
    rst = 1; step(); rst = 0; step();
    check("R1", "req cleared mid-block", {127'd0, dma_req}, 128'd0);
    pulse_phase();
    give_word(32'hA5A5_0001, 0);
    give_word(32'hA5A5_0002, 1);
    give_word(32'hA5A5_0003, 0);
    give_word(32'hA5A5_0004, 2);
    check("R1", "count restarted", blk_data, 128'hA5A5_0001_A5A5_0002_A5A5_0003_A5A5_0004);
    take_block();
    step();
    report();
  end
endmodule